// File: doc/BRIEF.md
# Translation Unit Control and Interrupt Registers

This block is the software-facing control plane of a page-translating memory management unit. A simple register bus (address, write strobe, write data, combinational read data) reaches a small set of registers. Software uses them to turn address translation on and off, to hold the unit in a stalled state, to recover from a page fault and to load the page-directory base pointer. The translation datapath reports page faults, read bus errors and whether any transactions are still outstanding. The block returns a translate-enable level and two one-cycle pulses that invalidate either the whole TLB or a single TLB line.

A fault is recorded with its logical address, its direction and the identifier of the bus master that issued it. Two interrupt causes feed a raw register. Software can set raw bits by writing to that register, which lets it test the interrupt line. A mask register selects which raw causes drive the single interrupt output. Writing ones to a clear register acknowledges causes.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset the directory base, fault address, raw and mask registers read zero, paging is off, no fault is active, `irq` is low, and status reads 0x1C when `xact_drained` and `replay_empty` are both high.
- R2: Writing command 0 to offset 0x08 sets status bit 0 (paging enabled) on the next cycle. Writing command 1 clears it. Command values above 6 have no effect.
- R3: Command 2 requests a stall. Status bit 2 rises only on a cycle after the request, and only when `xact_drained` is high. Command 3 drops bit 2 on the next cycle. While paging is off, bit 2 reads 1.
- R4: Command 2 written while status bit 1 (fault active) is set is ignored. Bit 2 stays low and bit 1 stays set.
- R5: A write to the directory base at offset 0x00 takes effect only while status bit 2 or bit 1 is set. Otherwise the register keeps its old value.
- R6: Command 6 returns the block to its reset state. The directory base reads zero on the next cycle, as do the mask, raw, fault address and all mode bits.
- R7: A `fault_req` while paging is on and no fault is active does four things: it stores `fault_vaddr` at offset 0x0C, sets status bit 1, sets bit 5 from `fault_is_write`, and puts `fault_bus_id` in bits 10:6. It also sets raw bit 0. Faults that arrive while a fault is active or while paging is off change nothing.
- R8: Command 5 clears status bit 1. The captured direction and bus identifier stay readable.
- R9: `xlate_en` is high exactly when paging is on, the stall is not active and no fault is active.
- R10: Raw interrupt register (0x14): bit 0 is page fault and bit 1 is read bus error, set by `rd_bus_err`. Writing ones to 0x14 sets bits. Writing ones to 0x18 clears bits. A hardware or written set wins over a clear in the same cycle.
- R11: Offset 0x20 reads raw AND mask (mask at 0x1C), and `irq` is the OR of those bits.
- R12: Command 4 produces a one-cycle `tlb_flush_all` pulse on the next cycle. A write to 0x10 produces a one-cycle `tlb_flush_line` pulse with `tlb_line_idx` equal to write-data bits 31:22.
- R13: Offsets 0x08, 0x10, 0x18 and every offset at or above 0x24 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fault_req | input | 1 | Datapath reports a translation fault this cycle |
| fault_vaddr | input | 32 | Logical address of the faulting access |
| fault_is_write | input | 1 | Faulting access was a write |
| fault_bus_id | input | 5 | Bus master identifier of the faulting access |
| rd_bus_err | input | 1 | Datapath saw a read bus error this cycle |
| xact_drained | input | 1 | No translated transactions are outstanding |
| replay_empty | input | 1 | Replay buffer of the datapath is empty |
| xlate_en | output | 1 | Translation may proceed |
| tlb_flush_all | output | 1 | One-cycle whole-TLB invalidate |
| tlb_flush_line | output | 1 | One-cycle single-line invalidate |
| tlb_line_idx | output | 10 | Directory index for the line invalidate |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are those where a mode interlock meets a second event. One is a stall request held back because transactions are still outstanding. Another is a stall command issued during an active fault. A third is a fault that arrives while a fault is already pending or while paging is off. The stimulus reaches each one on purpose: it holds `xact_drained` low across the stall request, and it issues the stall command and a second `fault_req` after a fault has been taken and before command 5. It also drives a clear write in the same cycle as `rd_bus_err` to test set-over-clear priority. A behavioural model tracks every register cycle by cycle, and the bench checks read data and all outputs against it.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

  localparam int unsigned OFF_DIR   = 'h00;
  localparam int unsigned OFF_STAT  = 'h04;
  localparam int unsigned OFF_CMD   = 'h08;
  localparam int unsigned OFF_FADDR = 'h0C;
  localparam int unsigned OFF_LINE  = 'h10;
  localparam int unsigned OFF_RAW   = 'h14;
  localparam int unsigned OFF_CLR   = 'h18;
  localparam int unsigned OFF_MASK  = 'h1C;
  localparam int unsigned OFF_MSTAT = 'h20;

  localparam int unsigned ST_PAGING = 0;
  localparam int unsigned ST_FAULT  = 1;
  localparam int unsigned ST_STALL  = 2;
  localparam int unsigned ST_IDLE   = 3;
  localparam int unsigned ST_REPLAY = 4;
  localparam int unsigned ST_WRITE  = 5;
  localparam int unsigned ST_BUSID  = 6;

  localparam int unsigned IRQ_FAULT  = 0;
  localparam int unsigned IRQ_BUSERR = 1;

  typedef enum logic [2:0] {
    CMD_PAGE_ON    = 3'd0,
    CMD_PAGE_OFF   = 3'd1,
    CMD_STALL_ON   = 3'd2,
    CMD_STALL_OFF  = 3'd3,
    CMD_FLUSH_ALL  = 3'd4,
    CMD_FAULT_DONE = 3'd5,
    CMD_HARD_RST   = 3'd6
  } mmu_cmd_e;

  typedef struct packed {
    logic page_on;
    logic page_off;
    logic stall_on;
    logic stall_off;
    logic flush_all;
    logic fault_done;
    logic hard_rst;
    logic wr_dir;
    logic wr_line;
    logic wr_raw;
    logic wr_clr;
    logic wr_mask;
  } mmu_wr_strb_t;

endpackage

// File: rtl/mmu_cmd_dec.sv
module mmu_cmd_dec
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output mmu_wr_strb_t      strb
);

  localparam int unsigned CODE_W = 3;

  logic hit_cmd;
  logic code_ok;

  assign hit_cmd = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
  assign code_ok = (bus_wdata[DATA_W-1:CODE_W] == '0);

  always_comb begin
    strb = '0;
    if (hit_cmd && code_ok) begin
      case (bus_wdata[CODE_W-1:0])
        CMD_PAGE_ON:    strb.page_on    = 1'b1;
        CMD_PAGE_OFF:   strb.page_off   = 1'b1;
        CMD_STALL_ON:   strb.stall_on   = 1'b1;
        CMD_STALL_OFF:  strb.stall_off  = 1'b1;
        CMD_FLUSH_ALL:  strb.flush_all  = 1'b1;
        CMD_FAULT_DONE: strb.fault_done = 1'b1;
        CMD_HARD_RST:   strb.hard_rst   = 1'b1;
        default:        ;
      endcase
    end
    strb.wr_dir  = bus_wr && (bus_addr == ADDR_W'(OFF_DIR));
    strb.wr_line = bus_wr && (bus_addr == ADDR_W'(OFF_LINE));
    strb.wr_raw  = bus_wr && (bus_addr == ADDR_W'(OFF_RAW));
    strb.wr_clr  = bus_wr && (bus_addr == ADDR_W'(OFF_CLR));
    strb.wr_mask = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));
  end

endmodule

// File: rtl/mmu_mode_ctl.sv
module mmu_mode_ctl #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BUSID_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_page_on,
  input  logic               cmd_page_off,
  input  logic               cmd_stall_on,
  input  logic               cmd_stall_off,
  input  logic               cmd_fault_done,
  input  logic               cmd_hard_rst,
  input  logic               xact_drained,
  input  logic               fault_req,
  input  logic [DATA_W-1:0]  fault_vaddr,
  input  logic               fault_is_write,
  input  logic [BUSID_W-1:0] fault_bus_id,
  output logic               paging_q,
  output logic               stall_act_q,
  output logic               fault_act_q,
  output logic               fault_take,
  output logic [DATA_W-1:0]  faddr_q,
  output logic               fwr_q,
  output logic [BUSID_W-1:0] fid_q
);

  logic               stall_req_q;
  logic               paging_d, stall_req_d, stall_act_d, fault_act_d;
  logic               cap_en;
  logic [DATA_W-1:0]  faddr_d;
  logic               fwr_d;
  logic [BUSID_W-1:0] fid_d;

  assign fault_take = fault_req && paging_q && !fault_act_q && !cmd_hard_rst;

  always_comb begin
    paging_d    = paging_q;
    stall_req_d = stall_req_q;
    stall_act_d = stall_act_q;
    fault_act_d = fault_act_q;
    if (cmd_hard_rst) begin
      paging_d    = 1'b0;
      stall_req_d = 1'b0;
      stall_act_d = 1'b0;
      fault_act_d = 1'b0;
    end else begin
      if (cmd_page_on)  paging_d = 1'b1;
      if (cmd_page_off) paging_d = 1'b0;
      if (cmd_stall_on && !fault_act_q) stall_req_d = 1'b1;
      if (cmd_stall_off) begin
        stall_req_d = 1'b0;
        stall_act_d = 1'b0;
      end else if (stall_req_q && xact_drained) begin
        stall_act_d = 1'b1;
      end
      if (fault_take)          fault_act_d = 1'b1;
      else if (cmd_fault_done) fault_act_d = 1'b0;
    end
  end

  assign cap_en  = fault_take || cmd_hard_rst;
  assign faddr_d = cmd_hard_rst ? '0 : fault_vaddr;
  assign fwr_d   = cmd_hard_rst ? 1'b0 : fault_is_write;
  assign fid_d   = cmd_hard_rst ? '0 : fault_bus_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paging_q    <= 1'b0;
      stall_req_q <= 1'b0;
      stall_act_q <= 1'b0;
      fault_act_q <= 1'b0;
    end else begin
      paging_q    <= paging_d;
      stall_req_q <= stall_req_d;
      stall_act_q <= stall_act_d;
      fault_act_q <= fault_act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q <= '0;
      fwr_q   <= 1'b0;
      fid_q   <= '0;
    end else if (cap_en) begin
      faddr_q <= faddr_d;
      fwr_q   <= fwr_d;
      fid_q   <= fid_d;
    end
  end

endmodule

// File: rtl/mmu_irq_unit.sv
module mmu_irq_unit #(
  parameter int unsigned NIRQ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_raw,
  input  logic            wr_clr,
  input  logic            wr_mask,
  input  logic            hard_rst,
  input  logic [NIRQ-1:0] wbits,
  input  logic [NIRQ-1:0] hw_set,
  output logic [NIRQ-1:0] raw_q,
  output logic [NIRQ-1:0] mask_q,
  output logic [NIRQ-1:0] masked,
  output logic            irq
);

  logic [NIRQ-1:0] raw_d, mask_d;
  logic [NIRQ-1:0] set_v, clr_v;
  logic            mask_en;

  assign set_v = (wr_raw ? wbits : '0) | hw_set;
  assign clr_v = wr_clr ? wbits : '0;

  always_comb begin
    if (hard_rst) raw_d = '0;
    else          raw_d = (raw_q & ~clr_v) | set_v;
  end

  assign mask_en = wr_mask || hard_rst;
  assign mask_d  = hard_rst ? '0 : wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BUSID_W = 5,
  parameter int unsigned IDX_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               fault_req,
  input  logic [DATA_W-1:0]  fault_vaddr,
  input  logic               fault_is_write,
  input  logic [BUSID_W-1:0] fault_bus_id,
  input  logic               rd_bus_err,
  input  logic               xact_drained,
  input  logic               replay_empty,
  output logic               xlate_en,
  output logic               tlb_flush_all,
  output logic               tlb_flush_line,
  output logic [IDX_W-1:0]   tlb_line_idx,
  output logic               irq
);

  localparam int unsigned NIRQ    = 2;
  localparam int unsigned IDX_LSB = DATA_W - IDX_W;
  localparam int unsigned STAT_W  = ST_BUSID + BUSID_W;

  mmu_wr_strb_t       strb;
  logic               paging_q, stall_act_q, fault_act_q, fault_take;
  logic [DATA_W-1:0]  faddr_q;
  logic               fwr_q;
  logic [BUSID_W-1:0] fid_q;
  logic [NIRQ-1:0]    raw_q, mask_q, masked, hw_set;
  logic [DATA_W-1:0]  dir_q, dir_d;
  logic               dir_en, stall_view;
  logic               flush_all_q, flush_line_q;
  logic [IDX_W-1:0]   lidx_q;
  logic [STAT_W-1:0]  stat_v;

  mmu_cmd_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .strb      (strb)
  );

  mmu_mode_ctl #(.DATA_W(DATA_W), .BUSID_W(BUSID_W)) u_mode (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_page_on    (strb.page_on),
    .cmd_page_off   (strb.page_off),
    .cmd_stall_on   (strb.stall_on),
    .cmd_stall_off  (strb.stall_off),
    .cmd_fault_done (strb.fault_done),
    .cmd_hard_rst   (strb.hard_rst),
    .xact_drained   (xact_drained),
    .fault_req      (fault_req),
    .fault_vaddr    (fault_vaddr),
    .fault_is_write (fault_is_write),
    .fault_bus_id   (fault_bus_id),
    .paging_q       (paging_q),
    .stall_act_q    (stall_act_q),
    .fault_act_q    (fault_act_q),
    .fault_take     (fault_take),
    .faddr_q        (faddr_q),
    .fwr_q          (fwr_q),
    .fid_q          (fid_q)
  );

  always_comb begin
    hw_set             = '0;
    hw_set[IRQ_FAULT]  = fault_take;
    hw_set[IRQ_BUSERR] = rd_bus_err;
  end

  mmu_irq_unit #(.NIRQ(NIRQ)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_raw   (strb.wr_raw),
    .wr_clr   (strb.wr_clr),
    .wr_mask  (strb.wr_mask),
    .hard_rst (strb.hard_rst),
    .wbits    (bus_wdata[NIRQ-1:0]),
    .hw_set   (hw_set),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .masked   (masked),
    .irq      (irq)
  );

  // Directory base: writable only while stalled (explicitly or implicitly) or faulted
  assign stall_view = stall_act_q || !paging_q;
  assign dir_en     = (strb.wr_dir && (stall_view || fault_act_q)) || strb.hard_rst;
  assign dir_d      = strb.hard_rst ? '0 : bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  // Invalidate pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_all_q  <= 1'b0;
      flush_line_q <= 1'b0;
    end else begin
      flush_all_q  <= strb.flush_all;
      flush_line_q <= strb.wr_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lidx_q <= '0;
    else if (strb.wr_line) lidx_q <= bus_wdata[IDX_LSB +: IDX_W];
  end

  assign tlb_flush_all  = flush_all_q;
  assign tlb_flush_line = flush_line_q;
  assign tlb_line_idx   = lidx_q;
  assign xlate_en       = paging_q && !stall_act_q && !fault_act_q;

  always_comb begin
    stat_v                     = '0;
    stat_v[ST_PAGING]          = paging_q;
    stat_v[ST_FAULT]           = fault_act_q;
    stat_v[ST_STALL]           = stall_view;
    stat_v[ST_IDLE]            = xact_drained;
    stat_v[ST_REPLAY]          = replay_empty;
    stat_v[ST_WRITE]           = fwr_q;
    stat_v[ST_BUSID +: BUSID_W] = fid_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_DIR):   bus_rdata = dir_q;
      ADDR_W'(OFF_STAT):  bus_rdata = DATA_W'(stat_v);
      ADDR_W'(OFF_FADDR): bus_rdata = faddr_q;
      ADDR_W'(OFF_RAW):   bus_rdata = DATA_W'(raw_q);
      ADDR_W'(OFF_MASK):  bus_rdata = DATA_W'(mask_q);
      ADDR_W'(OFF_MSTAT): bus_rdata = DATA_W'(masked);
      default:            bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mmu_ctl_chk.sv
module mmu_ctl_chk
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              fault_req,
  input logic              xact_drained,
  input logic              irq,
  input logic              tlb_flush_all,
  input logic              tlb_flush_line,
  input logic              paging_q,
  input logic              stall_act_q,
  input logic              fault_act_q,
  input logic [DATA_W-1:0] dir_q
);

  logic cmd_wr;
  assign cmd_wr = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));

  // R6
  hard_rst_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata == DATA_W'(6)) |=> (dir_q == '0));

  // R4
  stall_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata == DATA_W'(2) && fault_act_q && !stall_act_q) |=> (!stall_act_q && fault_act_q));

  // R3
  stall_needs_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_act_q) |-> $past(xact_drained));

  // R12
  flush_all_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_all |-> $past(cmd_wr && bus_wdata == DATA_W'(4)));

  // R12
  flush_line_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_line |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_LINE)));

  // R11
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_MASK) && bus_wdata[1:0] == 2'b00) |=> !irq);

  // R7
  fault_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req && paging_q && !fault_act_q && !(cmd_wr && bus_wdata == DATA_W'(6))) |=> fault_act_q);

endmodule

bind mmu_ctl_regs mmu_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_wr         (bus_wr),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .fault_req      (fault_req),
  .xact_drained   (xact_drained),
  .irq            (irq),
  .tlb_flush_all  (tlb_flush_all),
  .tlb_flush_line (tlb_flush_line),
  .paging_q       (paging_q),
  .stall_act_q    (stall_act_q),
  .fault_act_q    (fault_act_q),
  .dir_q          (dir_q)
);

// File: tb/test_mmu_ctl_regs.sv
module test_mmu_ctl_regs;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        fault_req;
  logic [31:0] fault_vaddr;
  logic        fault_is_write;
  logic [4:0]  fault_bus_id;
  logic        rd_bus_err;
  logic        xact_drained;
  logic        replay_empty;
  logic        xlate_en;
  logic        tlb_flush_all;
  logic        tlb_flush_line;
  logic [9:0]  tlb_line_idx;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  mmu_ctl_regs i_mmu_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_req(fault_req),
    .fault_vaddr(fault_vaddr), .fault_is_write(fault_is_write),
    .fault_bus_id(fault_bus_id), .rd_bus_err(rd_bus_err),
    .xact_drained(xact_drained), .replay_empty(replay_empty),
    .xlate_en(xlate_en), .tlb_flush_all(tlb_flush_all),
    .tlb_flush_line(tlb_flush_line), .tlb_line_idx(tlb_line_idx), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference state
  bit          m_pg, m_sreq, m_sact, m_flt, m_fwr, m_fa, m_fl;
  bit [31:0]   m_faddr, m_dir;
  bit [4:0]    m_fid;
  bit [1:0]    m_raw, m_mask;
  bit [9:0]    m_lidx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pg = 0; m_sreq = 0; m_sact = 0; m_flt = 0; m_fwr = 0; m_fa = 0; m_fl = 0;
      m_faddr = 0; m_dir = 0; m_fid = 0; m_raw = 0; m_mask = 0; m_lidx = 0;
    end else begin
      bit cw, take, sv, nsact;
      int code;
      bit [1:0] setb, clrb;
      cw   = bus_wr && bus_addr == 6'h08;
      code = cw ? int'(bus_wdata) : -1;
      if (code == 6) begin
        m_pg = 0; m_sreq = 0; m_sact = 0; m_flt = 0; m_fwr = 0; m_fa = 0; m_fl = 0;
        m_faddr = 0; m_dir = 0; m_fid = 0; m_raw = 0; m_mask = 0;
      end else begin
        sv   = m_sact || !m_pg;
        take = fault_req && m_pg && !m_flt;
        if (bus_wr && bus_addr == 6'h00 && (sv || m_flt)) m_dir = bus_wdata;
        m_fa = (code == 4);
        m_fl = bus_wr && bus_addr == 6'h10;
        if (m_fl) m_lidx = bus_wdata[31:22];
        nsact = m_sact;
        if (code == 3) nsact = 0;
        else if (m_sreq && xact_drained) nsact = 1;
        if (code == 3) m_sreq = 0;
        if (code == 2 && !m_flt) m_sreq = 1;
        m_sact = nsact;
        if (take) begin
          m_flt = 1; m_faddr = fault_vaddr; m_fwr = fault_is_write; m_fid = fault_bus_id;
        end else if (code == 5) m_flt = 0;
        if (code == 0) m_pg = 1;
        if (code == 1) m_pg = 0;
        setb = (bus_wr && bus_addr == 6'h14) ? bus_wdata[1:0] : 2'b00;
        clrb = (bus_wr && bus_addr == 6'h18) ? bus_wdata[1:0] : 2'b00;
        setb = setb | {rd_bus_err, take};
        m_raw = (m_raw & ~clrb) | setb;
        if (bus_wr && bus_addr == 6'h1C) m_mask = bus_wdata[1:0];
      end
    end
  end

  function automatic bit [31:0] model_read(input bit [5:0] a);
    case (a)
      6'h00: return m_dir;
      6'h04: return {21'b0, m_fid, m_fwr, replay_empty, xact_drained, (m_sact || !m_pg), m_flt, m_pg};
      6'h0C: return m_faddr;
      6'h14: return {30'b0, m_raw};
      6'h1C: return {30'b0, m_mask};
      6'h20: return {30'b0, m_raw & m_mask};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string addr_req(input bit [5:0] a);
    case (a)
      6'h00: return "R5";
      6'h04: return "R7";
      6'h0C: return "R7";
      6'h14: return "R10";
      6'h1C: return "R11";
      6'h20: return "R11";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(addr_req(bus_addr), bus_rdata, model_read(bus_addr));
      check("R11 irq", 32'(irq), 32'(|(m_raw & m_mask)));
      check("R9 xlate_en", 32'(xlate_en), 32'(m_pg && !m_sact && !m_flt));
      check("R12 flush_all", 32'(tlb_flush_all), 32'(m_fa));
      check("R12 flush_line", 32'(tlb_flush_line), 32'(m_fl));
      check("R12 line_idx", 32'(tlb_line_idx), 32'(m_lidx));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input bit [5:0] a, input bit [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input bit [5:0] a, input bit [31:0] exp, input string req);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    fault_req = 0; fault_vaddr = 0; fault_is_write = 0; fault_bus_id = 0;
    rd_bus_err = 0; xact_drained = 1; replay_empty = 1;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rd(6'h04, 32'h1C, "R1 status");
    rd(6'h00, 32'h0, "R1 dir");
    rd(6'h1C, 32'h0, "R1 mask");
    rd(6'h14, 32'h0, "R1 raw");
    check("R1 irq", 32'(irq), 32'h0);

    // R5 write while implicitly stalled, R6 hard reset clears it
    wr(6'h00, 32'hCAFE0000);
    rd(6'h00, 32'hCAFE0000, "R5 dir accepted");
    wr(6'h08, 32'd6);
    rd(6'h00, 32'h0, "R6 dir cleared");

    // R2 paging on, R9
    wr(6'h08, 32'd0);
    rd(6'h04, 32'h19, "R2 paging on");
    check("R9 xlate", 32'(xlate_en), 32'h1);
    wr(6'h08, 32'd9);
    rd(6'h04, 32'h19, "R2 bad code");
    wr(6'h00, 32'h00001234);
    rd(6'h00, 32'h0, "R5 dir ignored");

    // R3 stall waits for drain
    xact_drained = 0;
    wr(6'h08, 32'd2);
    idle(2);
    rd(6'h04, 32'h11, "R3 stall held off");
    xact_drained = 1;
    idle(2);
    rd(6'h04, 32'h1D, "R3 stall active");
    check("R9 xlate stalled", 32'(xlate_en), 32'h0);
    wr(6'h00, 32'h00400000);
    rd(6'h00, 32'h00400000, "R5 dir while stalled");
    bus_addr = 6'h04;
    wr(6'h08, 32'd3);
    rd(6'h04, 32'h19, "R3 stall off");

    // R12 pulses
    wr(6'h08, 32'd4);
    idle(2);
    wr(6'h10, 32'h80400000);
    idle(2);
    check("R12 idx", 32'(tlb_line_idx), 32'h201);

    // R7 fault capture
    wr(6'h1C, 32'h3);
    @(posedge clk); #1;
    fault_req = 1; fault_vaddr = 32'hDEAD1000; fault_is_write = 1; fault_bus_id = 5'h15;
    @(posedge clk); #1;
    fault_req = 0;
    rd(6'h04, 32'h57B, "R7 status");
    rd(6'h0C, 32'hDEAD1000, "R7 addr");
    rd(6'h14, 32'h1, "R7 raw");
    check("R11 irq fault", 32'(irq), 32'h1);
    @(posedge clk); #1;
    fault_req = 1; fault_vaddr = 32'h00000001; fault_is_write = 0; fault_bus_id = 5'h02;
    @(posedge clk); #1;
    fault_req = 0;
    rd(6'h0C, 32'hDEAD1000, "R7 second fault ignored");

    // R4 stall refused during fault
    wr(6'h08, 32'd2);
    idle(2);
    rd(6'h04, 32'h57B, "R4 stall refused");

    // R8 fault done
    wr(6'h08, 32'd5);
    rd(6'h04, 32'h579, "R8 fault cleared");
    check("R9 xlate resumed", 32'(xlate_en), 32'h1);
    wr(6'h18, 32'h1);
    check("R10 clear", 32'(irq), 32'h0);

    // R10/R11 bus error, mask, set priority, injection
    @(posedge clk); #1;
    rd_bus_err = 1;
    @(posedge clk); #1;
    rd_bus_err = 0;
    rd(6'h20, 32'h2, "R11 masked");
    wr(6'h1C, 32'h1);
    rd(6'h20, 32'h0, "R11 masked off");
    check("R11 irq masked", 32'(irq), 32'h0);
    @(posedge clk); #1;
    rd_bus_err = 1; bus_wr = 1; bus_addr = 6'h18; bus_wdata = 32'h2;
    @(posedge clk); #1;
    rd_bus_err = 0; bus_wr = 0; bus_wdata = 0;
    rd(6'h14, 32'h2, "R10 set wins");
    wr(6'h18, 32'h2);
    rd(6'h14, 32'h0, "R10 cleared");
    wr(6'h14, 32'h3);
    rd(6'h14, 32'h3, "R10 inject");
    rd(6'h20, 32'h1, "R11 inject masked");
    check("R11 irq inject", 32'(irq), 32'h1);

    // R13 zero reads
    rd(6'h08, 32'h0, "R13 cmd");
    rd(6'h10, 32'h0, "R13 line");
    rd(6'h18, 32'h0, "R13 clr");
    rd(6'h30, 32'h0, "R13 unmapped");

    // R2 paging off, R7 fault ignored while off
    wr(6'h08, 32'd1);
    rd(6'h04, 32'h57C, "R2 paging off");
    @(posedge clk); #1;
    fault_req = 1; fault_vaddr = 32'h12345678;
    @(posedge clk); #1;
    fault_req = 0;
    rd(6'h0C, 32'hDEAD1000, "R7 fault while off");

    // R6 hard reset clears all
    wr(6'h08, 32'd6);
    rd(6'h04, 32'h1C, "R6 status");
    rd(6'h1C, 32'h0, "R6 mask");
    rd(6'h14, 32'h0, "R6 raw");
    rd(6'h0C, 32'h0, "R6 faddr");
    check("R6 irq", 32'(irq), 32'h0);

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule